// File: doc/BRIEF.md
# Smart Card Character Engine (ISO 7816-3, T=0 level)

This block sends and receives asynchronous characters for a smart card host on one shared open-drain data line. A character is a low start bit, eight data bits and an even parity bit. Each bit lasts one elementary time unit (ETU). An ETU is `cfg_etu_clks` system clocks long; software normally programs 372. The block never drives the line high. It only asserts `io_drive_low`, and the external pull-up gives the idle high level. Transmit and receive share the line, so the receiver listens only while the transmitter is idle, and a new transmission waits until the receiver is idle.

Bytes to send enter a four-entry FIFO through a valid/ready port. A byte stays in the FIFO until the card accepts it. `tx_ready` falls while four bytes are held, and the producer must keep `tx_valid` and `tx_data` steady until it sees `tx_ready`. Received bytes leave a four-entry FIFO through a valid/ready port. `rx_data` is held while `rx_valid` is high and `rx_ready` is low. The line cannot be paused, so a character that arrives while that FIFO is full is lost.

Each side handles T=0 error signalling. The receiver reports bad parity on the line, and the transmitter resends a character the card rejects. Both stop after a programmed number of retries. The first valid initial character fixes direct or inverse convention for all later traffic until reset.

Top module: `sc_char_engine`

## Requirements
- R1: A transmitted character is a low start bit, then data bits as line levels (line high = 1), then the parity bit, each held for `cfg_etu_clks` clocks. In direct convention data goes least-significant bit first and the parity bit on the line is the XOR of the data. The block never drives the line from more than one source at once.
- R2: The transmit FIFO holds 4 bytes. `tx_ready` is low while 4 bytes are held, and bytes go out in the order they were accepted.
- R3: The receive FIFO holds 4 bytes and delivers them in arrival order. A valid character that arrives while it is full is dropped.
- R4: `rx_thresh` is high when the receive FIFO holds at least one byte and at least `cfg_rx_trig` bytes.
- R5: Between two transmitted start edges there are at least (11 + `cfg_guard_extra`) ETU. When data is waiting, the next start follows within 3 clocks of that bound.
- R6: When a received character fails parity, the block drives the line low from 10.5 ETU to 12 ETU after its start edge and does not store the character.
- R7: After `cfg_retry_limit` consecutive signalled parity errors, the next bad character is not signalled. It is discarded and `rx_err_limit` pulses for one clock. A good character clears the error run.
- R8: The transmitter samples the line 11 ETU after its start edge. If the line is low, it resends the same byte, starting no earlier than 13 ETU after the rejected start.
- R9: When a byte has been rejected `cfg_retry_limit` + 1 times in a row, it is dropped, `tx_err_limit` pulses for one clock, and the next byte is sent.
- R10: Before the convention is known, a received character with raw line data 0x3B (least-significant bit first) and a high parity bit sets direct convention and delivers 0x3B. Raw 0x03 with a high parity bit sets inverse convention and delivers 0x3F. Any other character is discarded with no error signal. `conv_valid` then stays high, and `conv_inverse` holds its value until reset.
- R11: In inverse convention, line data bit i (i = 0 first after the start bit) is the inverse of logical bit 7-i, and the parity bit on the line is the inverse of the even parity of the logical byte. This applies on both transmit and receive.
- R12: After reset, `io_drive_low`, `rx_valid`, `rx_thresh` and `conv_valid` are low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_etu_clks | input | 12 | Clocks per ETU (at least 4) |
| cfg_guard_extra | input | 8 | Guard time above 11 ETU, start to start |
| cfg_retry_limit | input | 3 | Number of retries allowed per character |
| cfg_rx_trig | input | 3 | Receive FIFO threshold level |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit FIFO can accept a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| rx_thresh | output | 1 | Receive FIFO at or above threshold |
| io_in | input | 1 | Sampled level of the data line |
| io_drive_low | output | 1 | Pull the data line low |
| conv_valid | output | 1 | Convention has been decided |
| conv_inverse | output | 1 | Inverse convention in use |
| tx_err_limit | output | 1 | One-clock pulse: transmit byte abandoned |
| rx_err_limit | output | 1 | One-clock pulse: received byte abandoned, not signalled |

## Verification
The bench plays the card on the shared line. It rejects chosen transmit attempts and sends characters with deliberately wrong parity. A design that counts its retries one too many or one too few shows up as an extra attempt, a missing error signal, or a limit pulse in the wrong place. Start-to-start spacing is measured in clocks, both after accepted characters and after rejected ones. A design that times the guard from the end of a character, or ignores the 13 ETU retry minimum, lands outside the window. Separate runs after reset try a junk first character, then the two valid initial characters. A design that locks the convention too early, or bit-reverses or inverts on only one side, returns wrong bytes or sets the wrong convention. Filling the receive FIFO past four bytes shows whether a fifth character corrupts the stored order.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned SC_GT_BASE = 11;
  localparam int unsigned SC_RETX_MIN = 13;
  localparam logic [8:0] SC_TS_DIRECT_RAW = 9'h13B;
  localparam logic [8:0] SC_TS_INVERSE_RAW = 9'h103;
  localparam logic [7:0] SC_TS_INVERSE_VAL = 8'h3F;

  typedef struct packed {
    logic [7:0] data;
    logic       ok;
  } sc_rx_char_t;

  function automatic logic [7:0] sc_flip(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // returns {parity line level, data line levels in send order}
  function automatic logic [8:0] sc_encode(input logic [7:0] d, input logic inv);
    if (inv) return {~(^d), ~sc_flip(d)};
    return {^d, d};
  endfunction

  function automatic sc_rx_char_t sc_decode(input logic [8:0] raw, input logic inv);
    sc_rx_char_t c;
    if (inv) begin
      c.data = sc_flip(~raw[7:0]);
      c.ok   = ((^c.data) == ~raw[8]);
    end else begin
      c.data = raw[7:0];
      c.ok   = ((^raw[7:0]) == raw[8]);
    end
    return c;
  endfunction
endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end

  // R2/R3: occupancy never passes the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_pkg::*;
#(
  parameter int ETU_W   = 12,
  parameter int GT_W    = 8,
  parameter int RETRY_W = 3,
  localparam int GC_W = GT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ETU_W-1:0]   cfg_etu,
  input  logic [GT_W-1:0]    cfg_guard_extra,
  input  logic [RETRY_W-1:0] cfg_retry_limit,
  input  logic               conv_inverse,
  input  logic               head_valid,
  input  logic [7:0]         head_data,
  output logic               head_pop,
  input  logic               rx_busy,
  input  logic               line_in,
  output logic               drive_low,
  output logic               idle,
  output logic               err_limit
);
  typedef enum logic { T_IDLE, T_SEND } tx_state_e;

  tx_state_e          state;
  logic [ETU_W-1:0]   gclk;
  logic [GC_W-1:0]    gcnt;
  logic [9:0]         frame;
  logic [RETRY_W-1:0] tries;
  logic               retry_pend;
  logic [GC_W-1:0]    guard_need, need;
  logic               etu_end, start, check_pt, at_limit;
  logic [8:0]         enc;

  assign etu_end    = (gclk == cfg_etu - ETU_W'(1));
  assign guard_need = GC_W'(SC_GT_BASE) + GC_W'(cfg_guard_extra);
  assign need       = (retry_pend && guard_need < GC_W'(SC_RETX_MIN)) ?
                      GC_W'(SC_RETX_MIN) : guard_need;
  assign start      = (state == T_IDLE) && head_valid && !rx_busy && (gcnt >= need);
  assign check_pt   = (state == T_SEND) && (gcnt == GC_W'(SC_GT_BASE)) && (gclk == '0);
  assign at_limit   = (tries == cfg_retry_limit);
  assign head_pop   = check_pt && (line_in || at_limit);
  assign drive_low  = (state == T_SEND) && !frame[0];
  assign idle       = (state == T_IDLE);
  assign enc        = sc_encode(head_data, conv_inverse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= T_IDLE;
      gclk       <= '0;
      gcnt       <= '1;
      frame      <= '1;
      tries      <= '0;
      retry_pend <= 1'b0;
      err_limit  <= 1'b0;
    end else begin
      err_limit <= 1'b0;
      // start-referenced ETU counter: bit timing and guard share it
      if (start) begin
        gclk <= '0;
        gcnt <= '0;
      end else if (etu_end) begin
        gclk <= '0;
        if (gcnt != '1) gcnt <= gcnt + GC_W'(1);
      end else begin
        gclk <= gclk + ETU_W'(1);
      end
      case (state)
        T_IDLE: if (start) begin
          state <= T_SEND;
          frame <= {enc, 1'b0};
        end
        T_SEND: begin
          if (etu_end) frame <= {1'b1, frame[9:1]};
          if (check_pt) begin
            state <= T_IDLE;
            if (!line_in) begin
              retry_pend <= 1'b1;
              if (at_limit) begin
                tries     <= '0;
                err_limit <= 1'b1;
              end else begin
                tries <= tries + RETRY_W'(1);
              end
            end else begin
              tries      <= '0;
              retry_pend <= 1'b0;
            end
          end
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  // R8: the byte on the line stays at the FIFO head until the verdict
  a_r8_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == T_SEND) |-> head_valid);
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_pkg::*;
#(
  parameter int ETU_W   = 12,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ETU_W-1:0]   cfg_etu,
  input  logic [RETRY_W-1:0] cfg_retry_limit,
  input  logic               enable,
  input  logic               line_in,
  input  logic               line_prev,
  output logic               push_valid,
  output logic [7:0]         push_data,
  output logic               drive_low,
  output logic               busy,
  output logic               conv_valid,
  output logic               conv_inverse,
  output logic               err_limit
);
  typedef enum logic [1:0] { R_IDLE, R_RECV, R_SIGNAL, R_WAIT } rx_state_e;

  rx_state_e          state;
  logic [ETU_W-1:0]   rclk, half;
  logic [3:0]         rbit;
  logic [8:0]         shift, full;
  logic [RETRY_W-1:0] errs;
  logic               mid, etu_end, decide;
  sc_rx_char_t        dec;

  assign half      = cfg_etu >> 1;
  assign mid       = (rclk == half);
  assign etu_end   = (rclk == cfg_etu - ETU_W'(1));
  assign decide    = (state == R_RECV) && mid && (rbit == 4'd9);
  assign full      = {line_in, shift[8:1]};
  assign dec       = sc_decode(full, conv_inverse);
  assign busy      = (state != R_IDLE);
  assign drive_low = (state == R_SIGNAL) &&
                     (((rbit == 4'd10) && (rclk >= half)) || (rbit == 4'd11));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= R_IDLE;
      rclk         <= '0;
      rbit         <= '0;
      shift        <= '0;
      errs         <= '0;
      conv_valid   <= 1'b0;
      conv_inverse <= 1'b0;
      push_valid   <= 1'b0;
      push_data    <= '0;
      err_limit    <= 1'b0;
    end else begin
      push_valid <= 1'b0;
      err_limit  <= 1'b0;
      if (state == R_RECV || state == R_SIGNAL) begin
        if (etu_end) begin
          rclk <= '0;
          rbit <= rbit + 4'd1;
        end else begin
          rclk <= rclk + ETU_W'(1);
        end
      end
      case (state)
        R_IDLE: if (enable && line_prev && !line_in) begin
          state <= R_RECV;
          rclk  <= '0;
          rbit  <= '0;
        end
        R_RECV: if (mid) begin
          if (rbit == 4'd0) begin
            if (line_in) state <= R_IDLE;
          end else begin
            shift <= {line_in, shift[8:1]};
          end
          if (decide) begin
            state <= R_WAIT;
            if (!conv_valid) begin
              if (full == SC_TS_DIRECT_RAW) begin
                conv_valid   <= 1'b1;
                conv_inverse <= 1'b0;
                push_valid   <= 1'b1;
                push_data    <= SC_TS_DIRECT_RAW[7:0];
              end else if (full == SC_TS_INVERSE_RAW) begin
                conv_valid   <= 1'b1;
                conv_inverse <= 1'b1;
                push_valid   <= 1'b1;
                push_data    <= SC_TS_INVERSE_VAL;
              end
            end else if (dec.ok) begin
              errs       <= '0;
              push_valid <= 1'b1;
              push_data  <= dec.data;
            end else if (errs == cfg_retry_limit) begin
              errs      <= '0;
              err_limit <= 1'b1;
            end else begin
              errs  <= errs + RETRY_W'(1);
              state <= R_SIGNAL;
            end
          end
        end
        R_SIGNAL: if (rbit == 4'd12) state <= R_WAIT;
        R_WAIT:   if (line_in) state <= R_IDLE;
        default:  state <= R_IDLE;
      endcase
    end
  end

  // R10: once decided, the convention never changes until reset
  a_r10_conv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> conv_valid);
  a_r10_conv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && $past(conv_valid)) |-> $stable(conv_inverse));
endmodule

// File: rtl/sc_char_engine.sv
module sc_char_engine #(
  parameter int ETU_W   = 12,
  parameter int GT_W    = 8,
  parameter int RETRY_W = 3,
  parameter int DEPTH   = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ETU_W-1:0]   cfg_etu_clks,
  input  logic [GT_W-1:0]    cfg_guard_extra,
  input  logic [RETRY_W-1:0] cfg_retry_limit,
  input  logic [CW-1:0]      cfg_rx_trig,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [7:0]         tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_thresh,
  input  logic               io_in,
  output logic               io_drive_low,
  output logic               conv_valid,
  output logic               conv_inverse,
  output logic               tx_err_limit,
  output logic               rx_err_limit
);
  logic          io_s1, io_s2, io_s3;
  logic          head_valid, head_pop, tx_drive, tx_idle;
  logic [7:0]    head_data;
  logic          rx_push, rx_drive, rx_busy;
  logic [7:0]    rx_push_data;
  logic [CW-1:0] tx_count, rx_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_s1        <= 1'b1;
      io_s2        <= 1'b1;
      io_s3        <= 1'b1;
      io_drive_low <= 1'b0;
    end else begin
      io_s1        <= io_in;
      io_s2        <= io_s1;
      io_s3        <= io_s2;
      io_drive_low <= tx_drive || rx_drive;
    end
  end

  sc_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(head_valid), .out_ready(head_pop), .out_data(head_data),
    .count(tx_count)
  );

  sc_char_tx #(.ETU_W(ETU_W), .GT_W(GT_W), .RETRY_W(RETRY_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cfg_etu(cfg_etu_clks), .cfg_guard_extra(cfg_guard_extra),
    .cfg_retry_limit(cfg_retry_limit), .conv_inverse(conv_inverse),
    .head_valid(head_valid), .head_data(head_data), .head_pop(head_pop),
    .rx_busy(rx_busy), .line_in(io_s2), .drive_low(tx_drive),
    .idle(tx_idle), .err_limit(tx_err_limit)
  );

  sc_char_rx #(.ETU_W(ETU_W), .RETRY_W(RETRY_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cfg_etu(cfg_etu_clks), .cfg_retry_limit(cfg_retry_limit),
    .enable(tx_idle), .line_in(io_s2), .line_prev(io_s3),
    .push_valid(rx_push), .push_data(rx_push_data), .drive_low(rx_drive),
    .busy(rx_busy), .conv_valid(conv_valid), .conv_inverse(conv_inverse),
    .err_limit(rx_err_limit)
  );

  sc_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(), .in_data(rx_push_data),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data),
    .count(rx_count)
  );

  assign rx_thresh = (rx_count != '0) && (rx_count >= cfg_rx_trig);

  // R1: transmitter and receiver never pull the line together
  a_r1_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_drive && rx_drive));
  // R4: the threshold flag implies a byte is offered
  a_r4_thresh_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_thresh |-> rx_valid);
endmodule

// File: tb/sc_char_engine_tb_top.sv
`timescale 1ns/1ps
module sc_char_engine_tb_top;
  localparam int ETU = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [11:0] cfg_etu_clks = 12'(ETU);
  logic [7:0] cfg_guard_extra = 8'd0;
  logic [2:0] cfg_retry_limit = 3'd2;
  logic [2:0] cfg_rx_trig = 3'd3;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rx_ready = 1'b0;
  logic       tx_ready, rx_valid, rx_thresh, io_drive_low;
  logic       conv_valid, conv_inverse, tx_err_limit, rx_err_limit;
  logic [7:0] rx_data;
  logic       card_drv = 1'b0;
  wire        io_line = ~(io_drive_low | card_drv);

  int checks = 0, fails = 0, cyc = 0, tx_lim_cnt = 0, rx_lim_cnt = 0;

  always #2.5 clk = ~clk;

  sc_char_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_etu_clks(cfg_etu_clks),
    .cfg_guard_extra(cfg_guard_extra), .cfg_retry_limit(cfg_retry_limit),
    .cfg_rx_trig(cfg_rx_trig), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_thresh(rx_thresh), .io_in(io_line),
    .io_drive_low(io_drive_low), .conv_valid(conv_valid),
    .conv_inverse(conv_inverse), .tx_err_limit(tx_err_limit),
    .rx_err_limit(rx_err_limit)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_err_limit) tx_lim_cnt <= tx_lim_cnt + 1;
    if (rx_err_limit) rx_lim_cnt <= rx_lim_cnt + 1;
  end

  function automatic logic [8:0] line_of(input logic [7:0] d, input logic inv);
    logic [8:0] l;
    if (!inv) begin
      l[7:0] = d;
      l[8] = ^d;
    end else begin
      for (int i = 0; i < 8; i++) l[i] = ~d[7-i];
      l[8] = ~(^d);
    end
    return l;
  endfunction

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
  endtask

  // card sends one character; checks the block's error signal
  task automatic card_send(input logic [8:0] raw, input logic exp_err, input string tag);
    @(negedge clk);
    card_drv = 1'b1;
    wclk(ETU);
    for (int i = 0; i < 9; i++) begin
      card_drv = ~raw[i];
      wclk(ETU);
    end
    card_drv = 1'b0;
    wclk(ETU + 4);
    chk(io_drive_low == exp_err, {tag, " error signal at 11 ETU"}, io_drive_low, exp_err);
    wclk(2 * ETU);
    if (exp_err) chk(io_drive_low == 1'b0, {tag, " error signal released"}, io_drive_low, 0);
    wclk(ETU);
  endtask

  // card receives one character, optionally rejecting it
  task automatic card_recv(input logic reject, output logic [8:0] raw, output int t0);
    logic st;
    while (!io_drive_low) @(negedge clk);
    t0 = cyc;
    wclk(ETU / 2);
    st = io_line;
    for (int i = 0; i < 9; i++) begin
      wclk(ETU);
      raw[i] = io_line;
    end
    chk(st == 1'b0, "R1 start bit low", st, 0);
    wclk(ETU);
    if (reject) begin
      card_drv = 1'b1;
      wclk(ETU + ETU / 2);
      card_drv = 1'b0;
    end
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(rx_valid == 1'b1, {tag, " byte present"}, rx_valid, 1);
    chk(rx_data == exp, {tag, " byte value"}, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(io_drive_low == 0, "R12 line released", io_drive_low, 0);
    chk(rx_valid == 0, "R12 rx empty", rx_valid, 0);
    chk(rx_thresh == 0, "R12 thresh low", rx_thresh, 0);
    chk(conv_valid == 0, "R12 convention unknown", conv_valid, 0);
    chk(tx_ready == 1, "R12 tx ready", tx_ready, 1);
  endtask

  task automatic t_ts_direct;
    card_send(9'h055, 1'b0, "R10 junk first char");
    chk(conv_valid == 0, "R10 junk leaves convention open", conv_valid, 0);
    chk(rx_valid == 0, "R10 junk discarded", rx_valid, 0);
    card_send(9'h13B, 1'b0, "R10 direct TS");
    chk(conv_valid == 1 && conv_inverse == 0, "R10 direct selected",
        {conv_valid, conv_inverse}, 2'b10);
    drain(8'h3B, "R10 direct TS");
  endtask

  task automatic t_rx_fifo;
    logic [7:0] v [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    for (int i = 0; i < 5; i++) begin
      card_send(line_of(v[i], 1'b0), 1'b0, "R3 fill");
      if (i == 1) chk(rx_thresh == 0, "R4 thresh below trigger", rx_thresh, 0);
      if (i == 2) chk(rx_thresh == 1, "R4 thresh at trigger", rx_thresh, 1);
    end
    for (int i = 0; i < 4; i++) drain(v[i], "R3 order");
    @(negedge clk);
    chk(rx_valid == 0, "R3 fifth char dropped", rx_valid, 0);
  endtask

  task automatic t_rx_parity;
    logic [8:0] bad;
    bad = line_of(8'h5A, 1'b0) ^ 9'h100;
    card_send(bad, 1'b1, "R6 first bad parity");
    card_send(bad, 1'b1, "R6 second bad parity");
    chk(rx_lim_cnt == 0, "R7 no limit yet", rx_lim_cnt, 0);
    card_send(bad, 1'b0, "R7 third bad not signalled");
    chk(rx_lim_cnt == 1, "R7 limit pulse", rx_lim_cnt, 1);
    chk(rx_valid == 0, "R6 bad chars not stored", rx_valid, 0);
    card_send(line_of(8'hC3, 1'b0), 1'b0, "R7 good char");
    card_send(bad, 1'b1, "R7 run cleared by good char");
    drain(8'hC3, "R7 good char");
  endtask

  task automatic t_tx_fifo_guard;
    logic [7:0] v [4] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
    cfg_guard_extra = 8'd5;
    fork
      begin
        for (int i = 0; i < 4; i++) push_tx(v[i]);
        chk(tx_ready == 0, "R2 ready low with four held", tx_ready, 0);
      end
      begin
        logic [8:0] raw;
        int t, tp;
        tp = 0;
        for (int i = 0; i < 4; i++) begin
          card_recv(1'b0, raw, t);
          chk(raw == line_of(v[i], 1'b0), "R1 R2 direct line bits in order", raw, line_of(v[i], 1'b0));
          if (i > 0) chk(t - tp >= 16 * ETU && t - tp <= 16 * ETU + 3,
                         "R5 guard 16 ETU start to start", t - tp, 16 * ETU);
          tp = t;
        end
      end
    join
    cfg_guard_extra = 8'd0;
    wclk(4 * ETU);
  endtask

  task automatic t_tx_retry;
    fork
      begin
        push_tx(8'h33);
        push_tx(8'h44);
      end
      begin
        logic [8:0] raw;
        int t0, t1, t2;
        card_recv(1'b1, raw, t0);
        card_recv(1'b0, raw, t1);
        chk(raw == line_of(8'h33, 1'b0), "R8 same byte resent", raw, line_of(8'h33, 1'b0));
        chk(t1 - t0 >= 13 * ETU && t1 - t0 <= 13 * ETU + 3, "R8 resend spacing", t1 - t0, 13 * ETU);
        card_recv(1'b0, raw, t2);
        chk(raw == line_of(8'h44, 1'b0), "R8 next byte follows", raw, line_of(8'h44, 1'b0));
        chk(t2 - t1 >= 11 * ETU && t2 - t1 <= 11 * ETU + 3, "R5 minimum guard 11 ETU", t2 - t1, 11 * ETU);
      end
    join
    chk(tx_lim_cnt == 0, "R8 no limit pulse", tx_lim_cnt, 0);
    wclk(4 * ETU);
  endtask

  task automatic t_tx_limit;
    fork
      begin
        push_tx(8'h66);
        push_tx(8'h77);
      end
      begin
        logic [8:0] raw;
        int t, tp;
        tp = 0;
        for (int i = 0; i < 3; i++) begin
          card_recv(1'b1, raw, t);
          chk(raw == line_of(8'h66, 1'b0), "R9 attempt carries rejected byte", raw, line_of(8'h66, 1'b0));
          tp = t;
        end
        card_recv(1'b0, raw, t);
        chk(raw == line_of(8'h77, 1'b0), "R9 next byte after abandon", raw, line_of(8'h77, 1'b0));
        chk(t - tp >= 13 * ETU, "R9 spacing after abandon", t - tp, 13 * ETU);
      end
    join
    chk(tx_lim_cnt == 1, "R9 one limit pulse", tx_lim_cnt, 1);
    wclk(4 * ETU);
  endtask

  task automatic t_inverse;
    do_reset();
    card_send(9'h103, 1'b0, "R10 inverse TS");
    chk(conv_valid == 1 && conv_inverse == 1, "R10 inverse selected",
        {conv_valid, conv_inverse}, 2'b11);
    drain(8'h3F, "R10 inverse TS");
    card_send(line_of(8'h5A, 1'b1), 1'b0, "R11 inverse receive");
    drain(8'h5A, "R11 inverse receive");
    card_send(line_of(8'h5A, 1'b1) ^ 9'h100, 1'b1, "R11 inverse parity error");
    fork
      push_tx(8'hC1);
      begin
        logic [8:0] raw;
        int t;
        card_recv(1'b0, raw, t);
        chk(raw == line_of(8'hC1, 1'b1), "R11 inverse transmit", raw, line_of(8'hC1, 1'b1));
      end
    join
    wclk(4 * ETU);
  endtask

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(2);
    t_reset();
    t_ts_direct();
    t_rx_fifo();
    t_rx_parity();
    t_tx_fifo_guard();
    t_tx_retry();
    t_tx_limit();
    t_inverse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule